// File: doc/BRIEF.md
# Go-Back-N Link Retransmission Controller

This block protects one network-on-chip link against transient wire errors using error detection and go-back-N replay. The sender side encodes each flit with interleaved parity and launches it on the link. The same launch slot also enters a short shift history whose depth equals the link round trip. The receiver side checks every arriving codeword. On a parity error it discards that flit, sends one retransmit request back, and then drops every later first-copy flit until the replayed copies arrive. When the request reaches the sender, the sender holds off its source and resends its whole history, oldest slot first. That history starts with the faulty flit. Nothing is ever acknowledged. A slot simply falls off the end of the history once it is older than the round trip.

Each flit may be replayed only once. If a replayed copy also fails its check, the link is treated as permanently broken. A sticky fault flag rises, nothing more is delivered, and the source stays stalled until reset. The channel between the two halves is modelled inside the block as a register pipeline of `LINK_LAT` stages in each direction. An error-injection input XORs a mask onto the codeword as it enters the forward channel, so the whole loop can be driven from the ports.

Top module: `gbn_link`

## Requirements
- R1: The codeword is `{parity[PAR_GROUPS-1:0], data[DATA_W-1:0]}`. Parity bit g (codeword bit DATA_W+g) is the even parity of the data bits i with i mod PAR_GROUPS equal to g. Any single flipped codeword bit, whether data or parity, is detected.
- R2: A flit whose check fails is not delivered and causes exactly one retransmit request. First-copy flits that arrive after it are dropped until the first replayed copy arrives.
- R3: A retransmit request holds `src_stall` high for exactly RTT = 2*LINK_LAT+2 consecutive cycles. During that time the sender resends its last RTT launch slots, oldest first, beginning with the faulty flit.
- R4: The replay history holds exactly RTT slots and needs no release. A flit launched more than RTT cycles before a request is never resent.
- R5: While no permanent fault exists, the delivered flits equal the accepted flits in number, order and value, with no duplicates.
- R6: With no error in flight, a flit accepted at a clock edge appears on `out_valid`/`out_data` exactly LINK_LAT+1 edges later.
- R7: A check failure on a replayed copy sets `perm_fault`, which stays set until reset. From the next cycle on, nothing is delivered and `src_stall` stays high.
- R8: After reset, `out_valid`, `src_stall` and `perm_fault` are low.
- R9: A non-zero `chan_flip` during a cycle in which no flit is being launched has no effect: no stall and no output follow.
- R10: A flit is accepted at a rising edge exactly when `src_valid` is high and `src_stall` is low in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source offers a flit |
| src_data | input | DATA_W | Flit payload |
| src_stall | output | 1 | Source must hold its flit |
| chan_flip | input | DATA_W+PAR_GROUPS | Error mask XORed onto the codeword entering the channel |
| out_valid | output | 1 | Delivered flit valid |
| out_data | output | DATA_W | Delivered flit payload |
| perm_fault | output | 1 | Sticky permanent link fault |

## Verification
The hardest situation to reach is a second error that lands on the replayed copy of a flit, because replayed words carry no visible marker at the ports. The bench counts cycles from the launch of a corrupted flit. It injects the second flip exactly RTT cycles later, which is when the replayed copy sits on the channel input. In the random phase, flips are allowed only in cycles that follow a cycle with `src_stall` low. This guarantees that random errors hit first copies only, so replays are exercised many times without tripping the fault flag before the directed test does.

// File: rtl/gbn_pkg.sv
package gbn_pkg;

   typedef enum logic [1:0] {
      RX_PASS = 2'd0,
      RX_SKIP = 2'd1,
      RX_DEAD = 2'd2
   } rx_state_t;

   function automatic int round_trip(input int link_lat);
      return 2 * link_lat + 2;
   endfunction

endpackage

// File: rtl/gbn_parity.sv
module gbn_parity #(
   parameter int DATA_W = 16,
   parameter int GROUPS = 4
) (
   input  logic [DATA_W-1:0] data,
   output logic [GROUPS-1:0] par
);

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      always_comb begin
         par[g] = 1'b0;
         for (int i = 0; i < DATA_W; i++) begin
            if ((i % GROUPS) == g) par[g] = par[g] ^ data[i];
         end
      end
   end

endmodule

// File: rtl/gbn_pipe.sv
module gbn_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 1) begin : g_bad
      $error("gbn_pipe: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= din;
      end
      assign dout = q;
   end else begin : g_many
      logic [STAGES*W-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[(STAGES-1)*W-1:0], din};
      end
      assign dout = sh[STAGES*W-1 -: W];
   end

endmodule

// File: rtl/gbn_tx.sv
module gbn_tx #(
   parameter int DATA_W = 16,
   parameter int GROUPS = 4,
   parameter int RTT    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     src_valid,
   input  logic [DATA_W-1:0]        src_data,
   output logic                     src_stall,
   input  logic                     nak_in,
   input  logic                     halt_in,
   output logic                     tx_valid,
   output logic                     tx_rtx,
   output logic [DATA_W+GROUPS-1:0] tx_code
);

   localparam int CW    = DATA_W + GROUPS;
   localparam int SW    = CW + 2;
   localparam int CNT_W = $clog2(RTT + 1);

   if (RTT < 2) begin : g_bad
      $error("gbn_tx: RTT must be at least 2");
   end

   logic [GROUPS-1:0] enc_par;
   logic [SW-1:0]     hist [RTT];
   logic              rp_act;
   logic [CNT_W-1:0]  rp_left;
   logic [SW-1:0]     oldest;

   gbn_parity #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_enc (
      .data (src_data),
      .par  (enc_par)
   );

   assign oldest    = hist[RTT-1];
   assign src_stall = nak_in | rp_act | halt_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RTT; i++) hist[i] <= '0;
         rp_act  <= 1'b0;
         rp_left <= '0;
      end else begin
         for (int i = 1; i < RTT; i++) hist[i] <= hist[i-1];
         if (nak_in || rp_act) begin
            hist[0] <= {oldest[SW-1], 1'b1, oldest[CW-1:0]};
         end else if (src_valid && !halt_in) begin
            hist[0] <= {1'b1, 1'b0, enc_par, src_data};
         end else begin
            hist[0] <= '0;
         end
         if (nak_in) begin
            rp_act  <= 1'b1;
            rp_left <= CNT_W'(RTT - 1);
         end else if (rp_act) begin
            rp_left <= rp_left - 1'b1;
            rp_act  <= (rp_left != CNT_W'(1));
         end
      end
   end

   assign tx_valid = hist[0][SW-1];
   assign tx_rtx   = hist[0][SW-2];
   assign tx_code  = hist[0][CW-1:0];

   AST_REQ_STARTS_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
      nak_in |=> tx_rtx); // R3
   AST_REPLAY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rp_act) |-> $past(nak_in)); // R3
   AST_ONE_REPLAY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      nak_in |-> !rp_act); // R7

endmodule

// File: rtl/gbn_rx.sv
module gbn_rx
   import gbn_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int GROUPS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rx_valid,
   input  logic                     rx_rtx,
   input  logic [DATA_W+GROUPS-1:0] rx_code,
   output logic                     out_valid,
   output logic [DATA_W-1:0]        out_data,
   output logic                     nak,
   output logic                     perm
);

   rx_state_t         state;
   logic [GROUPS-1:0] chk_par;
   logic              bad;

   gbn_parity #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_chk (
      .data (rx_code[DATA_W-1:0]),
      .par  (chk_par)
   );

   assign bad = |(chk_par ^ rx_code[DATA_W+GROUPS-1:DATA_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_PASS;
         out_valid <= 1'b0;
         out_data  <= '0;
         nak       <= 1'b0;
         perm      <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         nak       <= 1'b0;
         case (state)
            RX_PASS: if (rx_valid) begin
               if (!bad) begin
                  out_valid <= 1'b1;
                  out_data  <= rx_code[DATA_W-1:0];
               end else if (rx_rtx) begin
                  state <= RX_DEAD;
                  perm  <= 1'b1;
               end else begin
                  state <= RX_SKIP;
                  nak   <= 1'b1;
               end
            end
            RX_SKIP: if (rx_valid && rx_rtx) begin
               if (!bad) begin
                  out_valid <= 1'b1;
                  out_data  <= rx_code[DATA_W-1:0];
                  state     <= RX_PASS;
               end else begin
                  state <= RX_DEAD;
                  perm  <= 1'b1;
               end
            end
            default: state <= RX_DEAD;
         endcase
      end
   end

   AST_NAK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nak |=> !nak); // R2
   AST_NAK_NOT_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
      nak |-> !out_valid); // R2
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      perm |=> perm); // R7
   AST_SILENT_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      perm |=> !out_valid); // R7

endmodule

// File: rtl/gbn_link.sv
module gbn_link #(
   parameter int DATA_W     = 16,
   parameter int PAR_GROUPS = 4,
   parameter int LINK_LAT   = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         src_valid,
   input  logic [DATA_W-1:0]            src_data,
   output logic                         src_stall,
   input  logic [DATA_W+PAR_GROUPS-1:0] chan_flip,
   output logic                         out_valid,
   output logic [DATA_W-1:0]            out_data,
   output logic                         perm_fault
);

   localparam int CW  = DATA_W + PAR_GROUPS;
   localparam int RTT = gbn_pkg::round_trip(LINK_LAT);

   if (PAR_GROUPS < 1 || PAR_GROUPS > DATA_W) begin : g_bad_groups
      $error("gbn_link: PAR_GROUPS must lie in 1..DATA_W");
   end
   if (LINK_LAT < 1) begin : g_bad_lat
      $error("gbn_link: LINK_LAT must be at least 1");
   end

   logic          tx_valid, tx_rtx;
   logic [CW-1:0] tx_code;
   logic          rx_valid, rx_rtx;
   logic [CW-1:0] rx_code;
   logic          nak_rx, nak_tx;

   gbn_tx #(.DATA_W(DATA_W), .GROUPS(PAR_GROUPS), .RTT(RTT)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_data  (src_data),
      .src_stall (src_stall),
      .nak_in    (nak_tx),
      .halt_in   (perm_fault),
      .tx_valid  (tx_valid),
      .tx_rtx    (tx_rtx),
      .tx_code   (tx_code)
   );

   gbn_pipe #(.W(CW + 2), .STAGES(LINK_LAT)) u_fwd (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({tx_valid, tx_rtx, tx_code ^ chan_flip}),
      .dout  ({rx_valid, rx_rtx, rx_code})
   );

   gbn_pipe #(.W(1), .STAGES(LINK_LAT)) u_back (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (nak_rx),
      .dout  (nak_tx)
   );

   gbn_rx #(.DATA_W(DATA_W), .GROUPS(PAR_GROUPS)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_rtx    (rx_rtx),
      .rx_code   (rx_code),
      .out_valid (out_valid),
      .out_data  (out_data),
      .nak       (nak_rx),
      .perm      (perm_fault)
   );

endmodule

// File: tb/gbn_link_bench.sv
module gbn_link_bench;
   localparam int DW  = 16;
   localparam int PG  = 4;
   localparam int LAT = 1;
   localparam int CW  = DW + PG;
   localparam int RTT = 2 * LAT + 2;
   localparam int QD  = 8192;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          src_valid = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic [CW-1:0] chan_flip = '0;
   logic          src_stall, out_valid, perm_fault;
   logic [DW-1:0] out_data;

   gbn_link #(.DATA_W(DW), .PAR_GROUPS(PG), .LINK_LAT(LAT)) u_gbn_link (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
      .src_stall(src_stall), .chan_flip(chan_flip), .out_valid(out_valid),
      .out_data(out_data), .perm_fault(perm_fault)
   );

   always #5 clk = ~clk;

   int          n_chk = 0, n_err = 0;
   int          cyc = 0;
   logic [DW-1:0] q_data [QD];
   int          q_cyc [QD];
   int          wr = 0, rd = 0;
   bit          lat_on = 0;
   bit          last_stall = 0;
   int          run = 0, max_run = 0;
   bit          done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R5 order/no duplicates, R6 latency, checked on every delivered flit
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (rd >= wr) chk(0, "R5 unexpected delivery", out_data, -1);
         else begin
            chk(out_data == q_data[rd], "R5 delivered order", out_data, q_data[rd]);
            if (lat_on) chk(cyc - q_cyc[rd] == LAT + 1, "R6 latency", cyc - q_cyc[rd], LAT + 1);
            rd++;
         end
      end
   end

   // one cycle: drive at negedge, record acceptance (R10), advance one edge
   task automatic step(input bit v, input logic [DW-1:0] d, input logic [CW-1:0] f);
      @(negedge clk);
      src_valid = v; src_data = d; chan_flip = f;
      #1;
      if (v && !src_stall) begin
         q_data[wr] = d; q_cyc[wr] = cyc + 1; wr++;
      end
      last_stall = src_stall;
      if (src_stall) begin run++; if (run > max_run) max_run = run; end
      else run = 0;
      @(posedge clk);
   endtask

   function automatic logic [CW-1:0] bit_mask(input int b);
      return CW'(1) << b;
   endfunction

   initial begin
      #(10 * 200000);
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1f2e3d4c));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 0, "R8 out_valid", out_valid, 0);
      chk(src_stall == 0, "R8 src_stall", src_stall, 0);
      chk(perm_fault == 0, "R8 perm_fault", perm_fault, 0);
      rst_n = 1'b1;

      // R6: fault-free latency, back-to-back flits
      lat_on = 1;
      for (int i = 0; i < 6; i++) step(1, DW'(16'h100 + i), '0);
      for (int i = 0; i < 6; i++) step(0, '0, '0);
      lat_on = 0;
      chk(rd == wr, "R6 all delivered", rd, wr);

      // R2/R3/R4: error on the second flit of a burst
      max_run = 0;
      step(1, 16'hA001, '0);
      step(1, 16'hA002, '0);
      step(1, 16'hA003, bit_mask(5));    // corrupts A002 on the channel
      for (int i = 4; i < 12; i++) step(1, DW'(16'hA000 + i), '0);
      for (int i = 0; i < 16; i++) step(0, '0, '0);
      chk(max_run == RTT, "R3 stall length", max_run, RTT);
      chk(rd == wr, "R5 burst fully delivered", rd, wr);
      chk(perm_fault == 0, "R2 no fault after one error", perm_fault, 0);

      // R1: flip a parity bit only
      max_run = 0;
      step(1, 16'hB0B0, '0);
      step(0, '0, bit_mask(DW + 2));
      for (int i = 0; i < 16; i++) step(0, '0, '0);
      chk(max_run == RTT, "R1 parity-bit error detected", max_run, RTT);
      chk(rd == wr, "R1 flit recovered", rd, wr);

      // R9: flips on empty slots are harmless
      max_run = 0;
      for (int i = 0; i < 8; i++) step(0, '0, '1);
      for (int i = 0; i < 6; i++) step(0, '0, '0);
      chk(max_run == 0, "R9 no stall from empty-slot flip", max_run, 0);
      chk(rd == wr, "R9 no spurious output", rd, wr);

      // R1/R2/R5: random traffic, errors only on first copies
      for (int i = 0; i < 3000; i++) begin
         logic [CW-1:0] f;
         f = '0;
         if (!last_stall && ($urandom % 10) == 0) f = bit_mask($urandom % CW);
         step(($urandom % 4) != 0, DW'($urandom), f);
      end
      for (int i = 0; i < 20; i++) step(0, '0, '0);
      chk(rd == wr, "R5 random traffic count", rd, wr);
      chk(perm_fault == 0, "R5 no fault in random", perm_fault, 0);
      chk(wr > 1500, "R10 acceptances happened", wr, 1500);

      // R7: error on the first copy, then on its replayed copy
      step(1, 16'hC001, '0);
      step(1, 16'hC002, bit_mask(1));    // step s: C001 corrupted
      for (int i = 1; i < RTT; i++) step(1, DW'(16'hC010 + i), '0);
      step(0, '0, bit_mask(9));          // step s+RTT: replayed C001
      for (int i = 0; i < 8; i++) step(0, '0, '0);
      begin
         int seen;
         seen = rd;
         chk(perm_fault == 1, "R7 fault raised", perm_fault, 1);
         for (int i = 0; i < 10; i++) step(1, DW'(16'hD000 + i), '0);
         chk(src_stall == 1, "R7 source held", src_stall, 1);
         chk(rd == seen, "R7 nothing delivered after fault", rd, seen);
         chk(perm_fault == 1, "R7 fault sticky", perm_fault, 1);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule